// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block sequences one successive-approximation conversion. A command carries a 3-bit channel number, a 2-bit final-sample-time code and an amplifier-bypass bit. While the sequencer is idle, a start request latches the command. The sequencer then walks through the sample phases and the resolution phase. Every phase step is gated by a conversion-clock enable, so the sequencer keeps to a slower conversion rate while running on the system clock.

In normal mode a short sample through the buffer amplifier comes first. A direct final sample onto the capacitor follows, and its length is chosen by the code. Ten resolution cycles then decide the result one bit at a time, most significant bit first. In each of them the sequencer presents a trial code to the DAC and reads back the external comparator. With the bypass bit set, the buffered phase is skipped. The result and the channel number come out together with a single-cycle done strobe.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held, and after it is released until a start is accepted, `busy`, `bufSample`, `directSample`, `doneStrobe`, `dacCode`, `resultData` and `resultChan` are all zero.
- R2: A start request is accepted only while the sequencer is idle. A request raised during a conversion changes neither the reported channel nor the length of that conversion.
- R3: With `cmdBypass`=0, the first phase after a start is the buffered sample. `bufSample` is high for exactly 2 enabled cycles.
- R4: With `cmdBypass`=1, the buffered phase is skipped. `directSample` is high from the first cycle after the start and `bufSample` never rises.
- R5: The final sample phase drives `directSample` for 2, 4, 8 or 16 enabled cycles, for `cmdFinal` codes 00, 01, 10 and 11 in that order. The sample and resolution phases never overlap.
- R6: The resolution phase lasts 10 enabled cycles. In each cycle `dacCode` equals the bits decided so far plus the current trial bit, starting with bit 9 (value 512). The trial bit is kept when `cmpHigh`=1 (input at or above the DAC level) and cleared otherwise.
- R7: Phase counters advance only on cycles where `convEn`=1, and the state holds when it is 0. The number of enabled busy cycles equals (0 if bypass, else 2) + final length + 10.
- R8: `doneStrobe` is high for exactly one system clock, with `busy` low. In that clock `resultData` carries the 10-bit result and `resultChan` the command's channel. The next clock is idle.
- R9: During a conversion `chanSel` carries the channel latched from the accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convEn | input | 1 | Conversion-clock enable; phases step only when high |
| startReq | input | 1 | Start request, taken only when idle |
| cmdChan | input | 3 | Channel number of the command |
| cmdFinal | input | 2 | Final sample time code (00=2, 01=4, 10=8, 11=16) |
| cmdBypass | input | 1 | Skip the buffered sample phase |
| cmpHigh | input | 1 | Comparator: input at or above DAC level |
| busy | output | 1 | Sample or resolution phase active |
| chanSel | output | 3 | Multiplexer channel select |
| bufSample | output | 1 | Buffered sample phase active |
| directSample | output | 1 | Direct final sample phase active |
| dacCode | output | 10 | Trial code for the DAC |
| doneStrobe | output | 1 | One-clock completion strobe |
| resultData | output | 10 | Conversion result, valid with doneStrobe |
| resultChan | output | 3 | Channel of the result, valid with doneStrobe |

## Verification
The phase outputs rise on the first clock edge after the start is taken. The bench counts enabled busy cycles from there until `doneStrobe` appears, and that count must equal initial + final + 10. The result is due in the clock right after the tenth enabled resolution cycle, and idle is due one clock later. Inputs change 1 ns after the rising edge and every output is read on the falling edge, so each count and compare sees settled values. The bench checks all eight bypass and final-code pairs, and also runs with a one-in-three enable and with a start request raised in mid-conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUF   = 3'd1,
    ST_FINAL = 3'd2,
    ST_RES   = 3'd3,
    ST_DONE  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic resStep;
  } dpCtrl_t;

endpackage

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
#(
  parameter int INIT_CYCLES = 2,
  parameter int RES_BITS    = 10,
  parameter int CODE_W      = 2,
  parameter int FINAL_BASE  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convEn,
  input  logic              startReq,
  input  logic [CODE_W-1:0] cmdFinal,
  input  logic              cmdBypass,
  output dpCtrl_t           ctrl,
  output logic              busy,
  output logic              bufSample,
  output logic              directSample,
  output logic              resActive,
  output logic              doneStrobe
);

  localparam int MAX_FINAL = FINAL_BASE << ((1 << CODE_W) - 1);
  localparam int MAX_A     = (MAX_FINAL > RES_BITS) ? MAX_FINAL : RES_BITS;
  localparam int MAX_LEN   = (MAX_A > INIT_CYCLES) ? MAX_A : INIT_CYCLES;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  seqState_t         stateQ, stateD;
  logic [CNT_W-1:0]  cntQ, cntD;
  logic [CODE_W-1:0] finalQ, finalD;
  logic [CNT_W-1:0]  newFinalLen, heldFinalLen;

  always_comb begin
    newFinalLen  = CNT_W'(FINAL_BASE) << cmdFinal;
    heldFinalLen = CNT_W'(FINAL_BASE) << finalQ;
  end

  always_comb begin
    stateD       = stateQ;
    cntD         = cntQ;
    finalD       = finalQ;
    ctrl.loadCmd = 1'b0;
    ctrl.resStep = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.loadCmd = 1'b1;
          finalD       = cmdFinal;
          if (cmdBypass) begin
            stateD = ST_FINAL;
            cntD   = newFinalLen - CNT_W'(1);
          end else begin
            stateD = ST_BUF;
            cntD   = CNT_W'(INIT_CYCLES - 1);
          end
        end
      end
      ST_BUF: begin
        if (convEn) begin
          if (cntQ == '0) begin
            stateD = ST_FINAL;
            cntD   = heldFinalLen - CNT_W'(1);
          end else begin
            cntD = cntQ - CNT_W'(1);
          end
        end
      end
      ST_FINAL: begin
        if (convEn) begin
          if (cntQ == '0) begin
            stateD = ST_RES;
            cntD   = CNT_W'(RES_BITS - 1);
          end else begin
            cntD = cntQ - CNT_W'(1);
          end
        end
      end
      ST_RES: begin
        if (convEn) begin
          ctrl.resStep = 1'b1;
          if (cntQ == '0) begin
            stateD = ST_DONE;
          end else begin
            cntD = cntQ - CNT_W'(1);
          end
        end
      end
      ST_DONE: begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
      default: begin
        stateD = ST_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      finalQ <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      finalQ <= finalD;
    end
  end

  always_comb begin
    bufSample    = (stateQ == ST_BUF);
    directSample = (stateQ == ST_FINAL);
    resActive    = (stateQ == ST_RES);
    doneStrobe   = (stateQ == ST_DONE);
    busy         = bufSample | directSample | resActive;
  end

  AST_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && startReq && !cmdBypass) |=> (stateQ == ST_BUF)); // R3
  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && startReq && cmdBypass) |=> (stateQ == ST_FINAL)); // R4
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufSample, directSample, resActive, doneStrobe})); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convEn) |=> ($stable(stateQ) && $stable(cntQ))); // R7
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |=> $stable(finalQ)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> (!doneStrobe && stateQ == ST_IDLE)); // R8

endmodule

// File: rtl/sarseq_dp.sv
module sarseq_dp
  import sarseq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CHAN_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [CHAN_W-1:0]   cmdChan,
  input  logic                cmpHigh,
  input  logic                busy,
  input  logic                resActive,
  input  logic                doneStrobe,
  output logic [CHAN_W-1:0]   chanSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] resultData,
  output logic [CHAN_W-1:0]   resultChan
);

  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [CHAN_W-1:0]   chanQ;
  logic [RES_BITS-1:0] sarQ;
  logic [RES_BITS-1:0] trialQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ  <= '0;
      sarQ   <= '0;
      trialQ <= '0;
    end else if (ctrl.loadCmd) begin
      chanQ  <= cmdChan;
      sarQ   <= '0;
      trialQ <= MSB_ONE;
    end else if (ctrl.resStep) begin
      if (cmpHigh) begin
        sarQ <= sarQ | trialQ;
      end
      trialQ <= trialQ >> 1;
    end
  end

  always_comb begin
    chanSel    = busy ? chanQ : '0;
    dacCode    = resActive ? (sarQ | trialQ) : '0;
    resultData = doneStrobe ? sarQ : '0;
    resultChan = doneStrobe ? chanQ : '0;
  end

  AST_TRIAL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    resActive |-> $onehot(trialQ)); // R6
  AST_SAR_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    resActive |-> ((sarQ & ((trialQ << 1) - RES_BITS'(1))) == '0)); // R6
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(chanQ)); // R9

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sarseq_pkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int RES_BITS    = 10,
  parameter int INIT_CYCLES = 2,
  parameter int CODE_W      = 2,
  parameter int FINAL_BASE  = 2,
  localparam int CHAN_W     = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convEn,
  input  logic                startReq,
  input  logic [CHAN_W-1:0]   cmdChan,
  input  logic [CODE_W-1:0]   cmdFinal,
  input  logic                cmdBypass,
  input  logic                cmpHigh,
  output logic                busy,
  output logic [CHAN_W-1:0]   chanSel,
  output logic                bufSample,
  output logic                directSample,
  output logic [RES_BITS-1:0] dacCode,
  output logic                doneStrobe,
  output logic [RES_BITS-1:0] resultData,
  output logic [CHAN_W-1:0]   resultChan
);

  dpCtrl_t ctrl;
  logic    resActive;

  sarseq_ctrl #(
    .INIT_CYCLES(INIT_CYCLES),
    .RES_BITS   (RES_BITS),
    .CODE_W     (CODE_W),
    .FINAL_BASE (FINAL_BASE)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .convEn      (convEn),
    .startReq    (startReq),
    .cmdFinal    (cmdFinal),
    .cmdBypass   (cmdBypass),
    .ctrl        (ctrl),
    .busy        (busy),
    .bufSample   (bufSample),
    .directSample(directSample),
    .resActive   (resActive),
    .doneStrobe  (doneStrobe)
  );

  sarseq_dp #(
    .RES_BITS(RES_BITS),
    .CHAN_W  (CHAN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cmdChan   (cmdChan),
    .cmpHigh   (cmpHigh),
    .busy      (busy),
    .resActive (resActive),
    .doneStrobe(doneStrobe),
    .chanSel   (chanSel),
    .dacCode   (dacCode),
    .resultData(resultData),
    .resultChan(resultChan)
  );

endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convEn = 1'b1;
  logic       startReq = 1'b0;
  logic [2:0] cmdChan = '0;
  logic [1:0] cmdFinal = '0;
  logic       cmdBypass = 1'b0;
  logic       cmpHigh;
  logic       busy, bufSample, directSample, doneStrobe;
  logic [2:0] chanSel, resultChan;
  logic [9:0] dacCode, resultData;
  logic [9:0] vin = '0;
  int         enMode = 0;
  int         divCnt = 0;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  // ideal comparator against the stored input level
  assign cmpHigh = (vin >= dacCode);

  sar_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .convEn(convEn), .startReq(startReq),
    .cmdChan(cmdChan), .cmdFinal(cmdFinal), .cmdBypass(cmdBypass),
    .cmpHigh(cmpHigh), .busy(busy), .chanSel(chanSel),
    .bufSample(bufSample), .directSample(directSample), .dacCode(dacCode),
    .doneStrobe(doneStrobe), .resultData(resultData), .resultChan(resultChan)
  );

  // enable pattern changes just after the rising edge
  always @(posedge clk) begin
    #1;
    if (enMode == 0) begin
      convEn = 1'b1;
    end else begin
      divCnt = (divCnt == 2) ? 0 : divCnt + 1;
      convEn = (divCnt == 0);
    end
  end

  // {chan, finalCode, bypass, vin}
  localparam logic [15:0] VEC [0:7] = '{
    {3'd0, 2'd0, 1'b0, 10'd0},
    {3'd1, 2'd1, 1'b0, 10'd1023},
    {3'd2, 2'd2, 1'b0, 10'd512},
    {3'd3, 2'd3, 1'b0, 10'd511},
    {3'd4, 2'd0, 1'b1, 10'd341},
    {3'd5, 2'd1, 1'b1, 10'd682},
    {3'd6, 2'd2, 1'b1, 10'd1},
    {3'd7, 2'd3, 1'b1, 10'd777}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runConv(input logic [2:0] ch, input logic [1:0] fc, input logic byp,
                         input logic [9:0] level, input bit interfere);
    int total = 0;
    int bufCnt = 0;
    int dirCnt = 0;
    int iter = 0;
    int firstBuf = -1;
    int firstDir = -1;
    int firstDac = -1;
    bit chanBad = 0;
    bit seenRes = 0;
    int expLen = (byp ? 0 : 2) + (2 << fc) + 10;
    @(posedge clk);
    #1;
    vin = level; cmdChan = ch; cmdFinal = fc; cmdBypass = byp; startReq = 1'b1;
    @(posedge clk);
    #1;
    startReq = 1'b0;
    cmdChan = ~ch;
    forever begin
      @(negedge clk);
      if (doneStrobe || iter > 2000) break;
      if (iter == 0) begin
        firstBuf = bufSample;
        firstDir = directSample;
      end
      if (busy && chanSel != ch) chanBad = 1;
      if (busy && convEn) total++;
      if (bufSample && convEn) bufCnt++;
      if (directSample && convEn) dirCnt++;
      if (!seenRes && busy && !bufSample && !directSample) begin
        seenRes = 1;
        firstDac = dacCode;
      end
      if (interfere && iter == 4) startReq = 1'b1;
      if (interfere && iter == 6) startReq = 1'b0;
      iter++;
    end
    chk(iter <= 2000, "R8 done strobe seen", iter, expLen);
    chk(firstBuf == !byp, "R3 buffered phase first", firstBuf, !byp);
    chk(firstDir == byp, "R4 direct phase first when bypassed", firstDir, byp);
    chk(bufCnt == (byp ? 0 : 2), "R3 buffered sample length", bufCnt, byp ? 0 : 2);
    chk(dirCnt == (2 << fc), "R5 final sample length", dirCnt, 2 << fc);
    chk(total == expLen, "R7 total enabled conversion length", total, expLen);
    chk(firstDac == 512, "R6 MSB trial first", firstDac, 512);
    chk(resultData == level, "R6 result value", resultData, level);
    chk(resultChan == ch, interfere ? "R2 channel kept despite restart" : "R8 result channel",
        resultChan, ch);
    chk(!chanBad, "R9 channel select held", chanBad, 0);
    chk(!busy, "R8 not busy with done", busy, 0);
    @(negedge clk);
    chk(!doneStrobe && !busy, "R8 single done then idle", doneStrobe, 0);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, bufSample, directSample, doneStrobe} == 4'b0, "R1 idle in reset",
        {busy, bufSample, directSample, doneStrobe}, 0);
    chk(dacCode == 0 && resultData == 0 && resultChan == 0, "R1 data zero in reset",
        dacCode, 0);
    @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, bufSample, directSample, doneStrobe} == 4'b0, "R1 idle after reset",
        {busy, bufSample, directSample, doneStrobe}, 0);

    // table walk over every bypass / final-code pair
    for (int i = 0; i < 8; i++) begin
      runConv(VEC[i][15:13], VEC[i][12:11], VEC[i][10], VEC[i][9:0], 1'b0);
    end

    // R2: start raised mid-conversion is ignored
    runConv(3'd5, 2'd1, 1'b0, 10'd300, 1'b1);
    runConv(3'd2, 2'd0, 1'b1, 10'd900, 1'b1);

    // R7: sparse conversion-clock enable
    enMode = 1;
    runConv(3'd3, 2'd2, 1'b0, 10'd613, 1'b0);
    runConv(3'd6, 2'd3, 1'b1, 10'd1022, 1'b0);
    enMode = 0;

    // back-to-back extremes
    runConv(3'd7, 2'd0, 1'b1, 10'd0, 1'b0);
    runConv(3'd0, 2'd0, 1'b0, 10'd1023, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule